// File: doc/BRIEF.md
# Pixel-Clock Line Counter with Alternate-Frame Skip

This block tracks image rows coming from a camera sensor. All of its logic runs on the
sensor's pixel clock. The sensor's line-valid strobe is treated as an ordinary data
input. A registered copy of the strobe finds each low-to-high transition. Each
transition advances a row counter. After a fixed number of rows the counter returns to
zero instead of advancing, and each such return inverts a frame-skip flag, so frames
alternate between kept and skipped.

In parallel, the pixel data bus is registered on every clock. A registered
qualified-valid bit travels with it. This bit is high only for pixels taken while the
strobe was high and the skip flag was set. A one-cycle pulse marks each counter return
to zero, so downstream logic can find frame boundaries.

Top module: `sensor_line_tracker`

## Requirements
- R1: A synchronous active-high reset sampled at a clock edge makes `lineCount`, `skipFlag`, `wrapPulse`, `pixOut` and `pixValid` all 0 after that edge, and clears the stored previous strobe value to 0.
- R2: At every clock edge outside reset, `pixOut` takes the value of `pixIn` sampled at that edge.
- R3: A rising edge of the strobe is detected at a clock edge where `lineStrobe` is 1 and the strobe sampled at the previous clock edge was 0. Each detected edge changes `lineCount` at that same clock edge, with no further delay.
- R4: Holding `lineStrobe` at 1 for any number of cycles yields exactly one count. Holding it at 0 yields none, and `lineCount` stays unchanged.
- R5: When an edge is detected while `lineCount` is 488 or less, `lineCount` becomes its old value plus 1. When an edge is detected while `lineCount` is greater than 488 (that is, 489), `lineCount` becomes 0. Rows per frame are therefore 490.
- R6: `skipFlag` inverts exactly at the edges where the counter returns to 0, and holds its value otherwise.
- R7: `wrapPulse` is 1 for exactly the cycle that follows a return of the counter to 0, and is 0 in all other cycles.
- R8: After each clock edge outside reset, `pixValid` equals the `lineStrobe` sampled at that edge AND the value `skipFlag` held just before that edge.
- R9: A strobe that is already high when reset is released counts as a rising edge at the first clock edge after reset, because the stored previous value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; the only clock of the block |
| rst | input | 1 | Synchronous reset, active high |
| lineStrobe | input | 1 | Line-valid strobe from the sensor, sampled as data |
| pixIn | input | DATA_W (10) | Pixel data from the sensor |
| pixOut | output | DATA_W (10) | Registered pixel data |
| pixValid | output | 1 | Registered qualified-valid, aligned with `pixOut` |
| lineCount | output | CNT_W (10) | Current row count |
| skipFlag | output | 1 | Frame-skip flag; inverts at each counter return to zero |
| wrapPulse | output | 1 | One-cycle pulse after the counter returns to zero |

## Verification
A corrupted previous-strobe register shows up on the very next clock as a missing or
extra step on `lineCount`. A faulty limit compare shows up at the wrap boundary: the
counter reaches 490 or wraps early, and `wrapPulse` fires on the wrong cycle. A skip
flag with the wrong value shows up as a wrong `pixValid` in the first strobe-high cycle
that follows. The reference model in the bench predicts every output one clock ahead,
so each of these faults is caught in the cycle where it first appears.

// File: rtl/line_trk_pkg.sv
package line_trk_pkg;

  // Strobes handed from the control half to the datapath half each cycle.
  typedef struct packed {
    logic strobeNow;  // line strobe as sampled this cycle
    logic skipHeld;   // skip flag value before this cycle's update
  } trkStrobes_t;

endpackage

// File: rtl/line_trk_ctrl.sv
module line_trk_ctrl
  import line_trk_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int LINE_LIMIT = 488
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineStrobe,
  output trkStrobes_t      strobes,
  output logic [CNT_W-1:0] lineCount,
  output logic             skipFlag,
  output logic             wrapPulse
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LINE_LIMIT);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  logic prevStrobe;
  logic lineEdge;
  logic pastLimit;

  // Edge found from the sampled level and its registered copy: no second clock.
  assign lineEdge  = lineStrobe & ~prevStrobe;
  assign pastLimit = (lineCount > LIMIT_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevStrobe <= 1'b0;
      lineCount  <= '0;
      skipFlag   <= 1'b0;
      wrapPulse  <= 1'b0;
    end else begin
      prevStrobe <= lineStrobe;
      wrapPulse  <= lineEdge & pastLimit;
      if (lineEdge) begin
        if (pastLimit) begin
          lineCount <= '0;
          skipFlag  <= ~skipFlag;
        end else begin
          lineCount <= lineCount + ONE_V;
        end
      end
    end
  end

  always_comb begin
    strobes.strobeNow = lineStrobe;
    strobes.skipHeld  = skipFlag;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (lineEdge && !pastLimit) |=> (lineCount == $past(lineCount) + ONE_V)); // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !lineEdge |=> $stable(lineCount)); // R4

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    lineCount <= LIMIT_V + ONE_V); // R5

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrapPulse |-> (lineCount == '0)); // R7

  AST_SKIP_FLIP: assert property (@(posedge clk) disable iff (rst)
    (lineEdge && pastLimit) |=> (skipFlag != $past(skipFlag))); // R6

  AST_SKIP_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(lineEdge && pastLimit) |=> $stable(skipFlag)); // R6

endmodule

// File: rtl/line_trk_dpath.sv
module line_trk_dpath
  import line_trk_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  trkStrobes_t       strobes,
  input  logic [DATA_W-1:0] pixIn,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixValid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pixOut   <= '0;
      pixValid <= 1'b0;
    end else begin
      pixOut   <= pixIn;
      pixValid <= strobes.strobeNow & strobes.skipHeld;
    end
  end

  AST_VALID_QUAL: assert property (@(posedge clk) disable iff (rst)
    pixValid |-> ($past(strobes.strobeNow) && $past(strobes.skipHeld))); // R8

  AST_VALID_LOW: assert property (@(posedge clk) disable iff (rst)
    !strobes.strobeNow |=> !pixValid); // R8

endmodule

// File: rtl/sensor_line_tracker.sv
module sensor_line_tracker
  import line_trk_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int CNT_W      = 10,
  parameter int LINE_LIMIT = 488
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineStrobe,
  input  logic [DATA_W-1:0] pixIn,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixValid,
  output logic [CNT_W-1:0]  lineCount,
  output logic              skipFlag,
  output logic              wrapPulse
);

  trkStrobes_t strobes;

  line_trk_ctrl #(
    .CNT_W     (CNT_W),
    .LINE_LIMIT(LINE_LIMIT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .lineStrobe(lineStrobe),
    .strobes   (strobes),
    .lineCount (lineCount),
    .skipFlag  (skipFlag),
    .wrapPulse (wrapPulse)
  );

  line_trk_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .pixIn   (pixIn),
    .pixOut  (pixOut),
    .pixValid(pixValid)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (lineCount == '0 && !skipFlag && !wrapPulse && !pixValid && pixOut == '0)); // R1

endmodule

// File: tb/sensor_line_tracker_bench.sv
module sensor_line_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 10;
  localparam int CNT_W      = 10;
  localparam int LINE_LIMIT = 488;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    bit              inReset;
    int              cnt;
    bit              skip;
    bit              wrap;
    bit              valid;
    logic [DATA_W-1:0] data;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lineStrobe = 1'b0;
  logic [DATA_W-1:0] pixIn = '0;
  logic [DATA_W-1:0] pixOut;
  logic              pixValid;
  logic [CNT_W-1:0]  lineCount;
  logic              skipFlag;
  logic              wrapPulse;

  int  checks = 0;
  int  failures = 0;
  int  wrapsSeen = 0;
  bit  finished = 0;

  // reference model state
  int  mCnt = 0;
  bit  mSkip = 0;
  bit  mPrev = 0;
  int  seed = 3;

  expItem_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_line_tracker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .LINE_LIMIT(LINE_LIMIT)
  ) u_sensor_line_tracker (
    .clk(clk), .rst(rst), .lineStrobe(lineStrobe), .pixIn(pixIn),
    .pixOut(pixOut), .pixValid(pixValid), .lineCount(lineCount),
    .skipFlag(skipFlag), .wrapPulse(wrapPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of inputs and pushes the predicted outputs.
  task automatic driveCycle(input bit r, input bit s);
    expItem_t e;
    bit edgeHit;
    @(negedge clk);
    seed = (seed * 73 + 41) % 1021;
    rst = r;
    lineStrobe = s;
    pixIn = DATA_W'(seed);
    e.inReset = r;
    if (r) begin
      mCnt = 0; mSkip = 0; mPrev = 0;
      e.cnt = 0; e.skip = 0; e.wrap = 0; e.valid = 0; e.data = '0;
    end else begin
      edgeHit = s && !mPrev;
      e.valid = s && mSkip;
      e.wrap  = edgeHit && (mCnt > LINE_LIMIT);
      if (edgeHit) begin
        if (mCnt > LINE_LIMIT) begin
          mCnt = 0; mSkip = !mSkip;
        end else begin
          mCnt = mCnt + 1;
        end
      end
      mPrev = s;
      e.cnt = mCnt; e.skip = mSkip; e.data = DATA_W'(seed);
    end
    sbQ.push_back(e);
  endtask

  // Monitor: compares design outputs shortly after each active edge.
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        e = sbQ.pop_front();
        if (e.inReset) begin
          chk("R1 lineCount", int'(lineCount), 0);
          chk("R1 skipFlag", int'(skipFlag), 0);
          chk("R1 wrapPulse", int'(wrapPulse), 0);
          chk("R1 pixValid", int'(pixValid), 0);
          chk("R1 pixOut", int'(pixOut), 0);
        end else begin
          chk("R3/R4/R5 lineCount", int'(lineCount), e.cnt);
          chk("R6 skipFlag", int'(skipFlag), int'(e.skip));
          chk("R7 wrapPulse", int'(wrapPulse), int'(e.wrap));
          chk("R8 pixValid", int'(pixValid), int'(e.valid));
          chk("R2 pixOut", int'(pixOut), int'(e.data));
          if (wrapPulse) wrapsSeen++;
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  task automatic runLines(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      int hi;
      int lo;
      hi = 1 + ((i + base) % 4);
      lo = 1 + ((i + base) % 3);
      if ((i % 97) == 7) hi = 40;  // R4: long hold gives one count
      for (int k = 0; k < hi; k++) driveCycle(0, 1);
      for (int k = 0; k < lo; k++) driveCycle(0, 0);
    end
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) driveCycle(1, 0);
    // R4: idle low produces no count
    for (int i = 0; i < 5; i++) driveCycle(0, 0);
    // R3, R5, R6, R7, R8: enough lines to wrap twice
    runLines(1000, 0);
    // R9: strobe high across reset release counts once
    for (int i = 0; i < 2; i++) driveCycle(1, 1);
    for (int i = 0; i < 6; i++) driveCycle(0, 1);
    driveCycle(0, 0);
    runLines(500, 1);
    for (int i = 0; i < 4; i++) driveCycle(0, 0);
    repeat (3) @(posedge clk);
    #2;
    chk("R7 wrap boundary reached at least three times", int'(wrapsSeen >= 3), 1);
    finishRun();
  end

endmodule